// File: doc/BRIEF.md
# Invertible-Operand Integer ALU with Control Decoder

This block is a purely combinational integer arithmetic-logic unit of parameterised width. A 4-bit control word selects the operation. The word has one flag that complements the first operand and one flag that complements the second operand. Its low two bits pick among a bitwise AND, a bitwise OR, an adder and a set-on-less-than stage. Subtract, NOR and signed comparison need no opcodes of their own: each is one setting of the invert flags combined with one of the four stages.

A small decoder in front of the datapath builds the control word. Its inputs are a 2-bit instruction-class code from the main control and a 6-bit function field used by register-register instructions. The block drives the result, a zero flag and a signed overflow flag. It also drives the decoded control word, so that neighbouring logic can see which operation was chosen. The datapath is built either as a chain of one-bit slices or as a flat behavioural adder, chosen by a parameter; both give the same outputs.

Top module: `bitslice_alu`

## Requirements
- R1: The control word `ctl_o` is ordered MSB to LSB as {invert first operand, invert second operand, op[1:0]}. The op codes are 00 = AND, 01 = OR, 10 = add, 11 = set-on-less-than.
- R2: The decoder maps class code 00 (load/store) to 0010 and class code 01 (branch-if-equal) to 0110. The unused class code 11 also maps to 0010.
- R3: With class code 10 (register-register), the function field is decoded as 0x20→0010, 0x22→0110, 0x24→0000, 0x25→0001, 0x27→1100 and 0x2A→0111. Any other function value gives 0000.
- R4: For op 00 and op 01, each result bit is the AND or the OR of the two effective operands. An effective operand is the input operand, complemented when its invert flag is set.
- R5: For op 10, the result is the sum of the effective operands plus a carry-in equal to the second-operand invert flag, modulo 2^WIDTH. Control 0010 therefore gives A+B, and control 0110 gives A−B.
- R6: Control 1100 gives the bitwise NOR of the two operands.
- R7: For op 11, result bit 0 equals the sign bit of A−B XOR the signed overflow of that subtraction, so it is 1 exactly when A < B as signed numbers. All other result bits are 0.
- R8: `ovf_o` is 1 only for op 10, and only when the carry into the MSB differs from the carry out of the MSB. For the other ops it is 0.
- R9: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R10: The slice-chain variant (USE_SLICES=1) and the behavioural variant (USE_SLICES=0) produce identical outputs for all inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Instruction-class code from main control |
| funct_i | input | 6 | Function field of a register-register instruction |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| ctl_o | output | 4 | Decoded control word {inv A, inv B, op} |
| result_o | output | WIDTH | ALU result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of the adder stage |

## Verification
Because the block holds no state, any fault shows at the ports in the same cycle the inputs are applied.
- A broken carry-in or carry link shows as a sum that is off by one or by a power of two. It appears mainly on operand pairs that ripple a carry across many bits.
- A wrong overflow correction on set-on-less-than flips bit 0 only when the operands have opposite signs and their difference overflows.
- A decoder slip shows as a wrong control word, together with a result from the wrong operation.

The sweep therefore covers every operand pair of a narrow instance, with every class code and function value, on both build variants.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      OP_AND = 2'b00,
      OP_OR  = 2'b01,
      OP_ADD = 2'b10,
      OP_SLT = 2'b11
   } alu_op_e;

   typedef struct packed {
      logic    inv_a;
      logic    inv_b;
      alu_op_e op;
   } alu_ctl_t;

   typedef enum logic [1:0] {
      CLS_MEM   = 2'b00,
      CLS_BEQ   = 2'b01,
      CLS_RTYPE = 2'b10,
      CLS_SPARE = 2'b11
   } alu_class_e;

   localparam int FUNCT_W = 6;

   localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
   localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
   localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
   localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
   localparam logic [FUNCT_W-1:0] FN_NOR = 6'h27;
   localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

   localparam alu_ctl_t CTL_ADD = '{inv_a: 1'b0, inv_b: 1'b0, op: OP_ADD};
   localparam alu_ctl_t CTL_SUB = '{inv_a: 1'b0, inv_b: 1'b1, op: OP_ADD};
   localparam alu_ctl_t CTL_AND = '{inv_a: 1'b0, inv_b: 1'b0, op: OP_AND};
   localparam alu_ctl_t CTL_OR  = '{inv_a: 1'b0, inv_b: 1'b0, op: OP_OR};
   localparam alu_ctl_t CTL_NOR = '{inv_a: 1'b1, inv_b: 1'b1, op: OP_AND};
   localparam alu_ctl_t CTL_SLT = '{inv_a: 1'b0, inv_b: 1'b1, op: OP_SLT};

endpackage

// File: rtl/alu_ctl_dec.sv
module alu_ctl_dec
   import alu_pkg::*;
(
   input  logic [1:0]         mode_i,
   input  logic [FUNCT_W-1:0] funct_i,
   output alu_ctl_t           ctl_o
);

   alu_ctl_t rtype_ctl;

   always_comb begin
      case (funct_i)
         FN_ADD:  rtype_ctl = CTL_ADD;
         FN_SUB:  rtype_ctl = CTL_SUB;
         FN_AND:  rtype_ctl = CTL_AND;
         FN_OR:   rtype_ctl = CTL_OR;
         FN_NOR:  rtype_ctl = CTL_NOR;
         FN_SLT:  rtype_ctl = CTL_SLT;
         default: rtype_ctl = CTL_AND;
      endcase
   end

   always_comb begin
      case (alu_class_e'(mode_i))
         CLS_MEM:   ctl_o = CTL_ADD;
         CLS_BEQ:   ctl_o = CTL_SUB;
         CLS_RTYPE: ctl_o = rtype_ctl;
         default:   ctl_o = CTL_ADD;
      endcase
   end

   always_comb begin
      // R2
      ctl_mem_chk: assert (!(mode_i == 2'b00) || (ctl_o.op == OP_ADD && !ctl_o.inv_b))
         else $error("load/store class did not decode to add");
      // R3
      ctl_inva_chk: assert (!ctl_o.inv_a || (ctl_o.inv_b && ctl_o.op == OP_AND))
         else $error("first-operand invert used outside NOR");
   end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_pkg::*;
(
   input  logic    a_i,
   input  logic    b_i,
   input  logic    inv_a_i,
   input  logic    inv_b_i,
   input  alu_op_e op_i,
   input  logic    cin_i,
   input  logic    less_i,
   output logic    res_o,
   output logic    sum_o,
   output logic    cout_o
);

   logic a_eff;
   logic b_eff;

   always_comb begin
      a_eff  = a_i ^ inv_a_i;
      b_eff  = b_i ^ inv_b_i;
      sum_o  = a_eff ^ b_eff ^ cin_i;
      cout_o = (a_eff & b_eff) | (cin_i & (a_eff ^ b_eff));
      case (op_i)
         OP_AND:  res_o = a_eff & b_eff;
         OP_OR:   res_o = a_eff | b_eff;
         OP_ADD:  res_o = sum_o;
         default: res_o = less_i;
      endcase
   end

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit USE_SLICES = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  alu_ctl_t         ctl_i,
   output logic [WIDTH-1:0] result_o,
   output logic             ovf_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] sum_w;
   logic             c_into_msb;
   logic             c_out_msb;
   logic             add_ovf;
   logic             set_lt;

   always_comb begin
      add_ovf = c_into_msb ^ c_out_msb;
      set_lt  = sum_w[MSB] ^ add_ovf;
      ovf_o   = (ctl_i.op == OP_ADD) & add_ovf;
   end

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_core: WIDTH must be at least 2");
   end

   if (USE_SLICES) begin : g_slices
      logic [WIDTH:0] carry;
      assign carry[0] = ctl_i.inv_b;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         alu_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (ctl_i.inv_a),
            .inv_b_i (ctl_i.inv_b),
            .op_i    (ctl_i.op),
            .cin_i   (carry[i]),
            .less_i  ((i == 0) ? set_lt : 1'b0),
            .res_o   (result_o[i]),
            .sum_o   (sum_w[i]),
            .cout_o  (carry[i+1])
         );
      end
      assign c_into_msb = carry[MSB];
      assign c_out_msb  = carry[WIDTH];
   end else begin : g_flat
      logic [WIDTH-1:0] a_eff;
      logic [WIDTH-1:0] b_eff;
      logic [MSB:0]     low_sum;
      logic [1:0]       top_sum;
      always_comb begin
         a_eff   = a_i ^ {WIDTH{ctl_i.inv_a}};
         b_eff   = b_i ^ {WIDTH{ctl_i.inv_b}};
         low_sum = {1'b0, a_eff[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]}
                   + {{(WIDTH-1){1'b0}}, ctl_i.inv_b};
         top_sum = {1'b0, a_eff[MSB]} + {1'b0, b_eff[MSB]} + {1'b0, low_sum[MSB]};
         sum_w   = {top_sum[0], low_sum[MSB-1:0]};
         case (ctl_i.op)
            OP_AND:  result_o = a_eff & b_eff;
            OP_OR:   result_o = a_eff | b_eff;
            OP_ADD:  result_o = sum_w;
            default: result_o = {{(WIDTH-1){1'b0}}, set_lt};
         endcase
      end
      assign c_into_msb = low_sum[MSB];
      assign c_out_msb  = top_sum[1];
   end

   always_comb begin
      // R5
      add_sum_chk: assert (!(ctl_i.op == OP_ADD && !ctl_i.inv_a)
                           || result_o == a_i + (ctl_i.inv_b ? ~b_i + 1'b1 : b_i))
         else $error("adder result does not match operand arithmetic");
      // R7
      slt_upper_chk: assert (ctl_i.op != OP_SLT || result_o[MSB:1] == '0)
         else $error("set-on-less-than drove upper result bits");
      // R8
      ovf_gate_chk: assert (!ovf_o || (ctl_i.op == OP_ADD
                            && a_eff_sign_ok(a_i[MSB] ^ ctl_i.inv_a, b_i[MSB] ^ ctl_i.inv_b,
                                             result_o[MSB])))
         else $error("overflow flagged without sign disagreement");
   end

   function automatic logic a_eff_sign_ok(input logic sa, input logic sb, input logic sr);
      return (sa == sb) && (sr != sa);
   endfunction

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit USE_SLICES = 1'b1
) (
   input  logic [1:0]       mode_i,
   input  logic [5:0]       funct_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   output logic [3:0]       ctl_o,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             ovf_o
);

   alu_ctl_t ctl;

   alu_ctl_dec u_dec (
      .mode_i  (mode_i),
      .funct_i (funct_i),
      .ctl_o   (ctl)
   );

   alu_core #(
      .WIDTH      (WIDTH),
      .USE_SLICES (USE_SLICES)
   ) u_core (
      .a_i      (opa_i),
      .b_i      (opb_i),
      .ctl_i    (ctl),
      .result_o (result_o),
      .ovf_o    (ovf_o)
   );

   assign ctl_o  = ctl;
   assign zero_o = ~|result_o;

   always_comb begin
      // R6
      nor_form_chk: assert (ctl_o != 4'b1100 || result_o == ~(opa_i | opb_i))
         else $error("NOR setting gave wrong result");
      // R9
      zero_slt_chk: assert (!(zero_o && ctl.op == OP_SLT) || !($signed(opa_i) < $signed(opb_i)))
         else $error("zero flag set although first operand is less");
   end

endmodule

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;

   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]   mode;
   logic [5:0]   funct;
   logic [W-1:0] opa, opb;
   logic [3:0]   ctl_s, ctl_f;
   logic [W-1:0] res_s, res_f;
   logic         zero_s, zero_f, ovf_s, ovf_f;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   bitslice_alu #(.WIDTH(W), .USE_SLICES(1'b1)) u_bitslice_alu (
      .mode_i(mode), .funct_i(funct), .opa_i(opa), .opb_i(opb),
      .ctl_o(ctl_s), .result_o(res_s), .zero_o(zero_s), .ovf_o(ovf_s));

   bitslice_alu #(.WIDTH(W), .USE_SLICES(1'b0)) u_flat (
      .mode_i(mode), .funct_i(funct), .opa_i(opa), .opb_i(opb),
      .ctl_o(ctl_f), .result_o(res_f), .zero_o(zero_f), .ovf_o(ovf_f));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s mode=%0d funct=%h a=%0d b=%0d actual=%0d expected=%0d",
                  req, mode, funct, opa, opb, act, exp);
      end
   endtask

   function automatic int exp_ctl(input int m, input int f);
      if (m == 0 || m == 3) return 4'b0010;
      if (m == 1) return 4'b0110;
      case (f)
         'h20: return 4'b0010;
         'h22: return 4'b0110;
         'h24: return 4'b0000;
         'h25: return 4'b0001;
         'h27: return 4'b1100;
         'h2A: return 4'b0111;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic apply(input int m, input int f, input int a, input int b);
      @(negedge clk);
      mode = 2'(m); funct = 6'(f); opa = W'(a); opb = W'(b);
      @(posedge clk);
      #1;
   endtask

   task automatic check_vec(input int m, input int f, input int a, input int b);
      int c, sa, sb, full, er, eo, ez;
      string tag;
      c  = exp_ctl(m, f);
      sa = (a >= 8) ? a - 16 : a;
      sb = (b >= 8) ? b - 16 : b;
      eo = 0;
      case (c)
         4'b0010: begin full = sa + sb; er = full & 15; eo = (full > 7 || full < -8); tag = "R5"; end
         4'b0110: begin full = sa - sb; er = full & 15; eo = (full > 7 || full < -8); tag = "R5"; end
         4'b0000: begin er = a & b; tag = "R4"; end
         4'b0001: begin er = a | b; tag = "R4"; end
         4'b1100: begin er = (~(a | b)) & 15; tag = "R6"; end
         default: begin er = (sa < sb) ? 1 : 0; tag = "R7"; end
      endcase
      ez = (er == 0);
      // R1 R2 R3: control word
      chk(int'(ctl_s) == c, (m == 2) ? "R3" : "R2", ctl_s, c);
      chk(int'(res_s) == er, tag, res_s, er);
      // R8
      chk(int'(ovf_s) == eo, "R8", ovf_s, eo);
      // R9
      chk(int'(zero_s) == ez, "R9", zero_s, ez);
      // R10
      chk(ctl_f == ctl_s && res_f == res_s && zero_f == zero_s && ovf_f == ovf_s,
          "R10", {ctl_f, res_f, zero_f, ovf_f}, {ctl_s, res_s, zero_s, ovf_s});
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
         end
      end
   end

   initial begin
      int fl[8];
      fl = '{'h20, 'h22, 'h24, 'h25, 'h27, 'h2A, 'h00, 'h3F};
      mode = 2'b00; funct = 6'h00; opa = '0; opb = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      // reset state: idle inputs give add of zeros (R1 R2 R9)
      chk(ctl_s == 4'b0010, "R1", ctl_s, 2);
      chk(res_s == '0 && zero_s && !ovf_s, "R9", {res_s, zero_s, ovf_s}, 2);
      // boundaries: 7+1 overflows, -8-1 overflows, slt with overflowing difference
      apply(2, 'h20, 7, 1);  chk(ovf_s && res_s == 4'd8, "R8", {res_s, ovf_s}, {4'd8, 1'b1});
      apply(1, 0, 8, 1);     chk(ovf_s && res_s == 4'd7, "R8", {res_s, ovf_s}, {4'd7, 1'b1});
      apply(2, 'h2A, 8, 7);  chk(res_s == 4'd1 && !ovf_s, "R7", res_s, 1);
      apply(2, 'h2A, 7, 8);  chk(res_s == 4'd0 && zero_s, "R7", res_s, 0);
      apply(2, 'h27, 0, 0);  chk(res_s == 4'hF, "R6", res_s, 15);
      for (int m = 0; m < 4; m++)
         for (int fi = 0; fi < 8; fi++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++) begin
                  apply(m, fl[fi], a, b);
                  check_vec(m, fl[fi], a, b);
               end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule